// File: doc/BRIEF.md
# PCIe Fundamental-Reset and Link-Up Sequencer

This block sits beside a root-port controller and runs the bring-up sequence for the downstream link. When it accepts a start strobe it drives the fundamental reset toward the link partner, which clears three reset-control outputs. It holds them cleared for a fixed interval and then raises only the root reset-out bit. It then waits a settle interval and polls a data-link-active bit in a link-status word at a fixed period, up to a bounded number of samples. The result is either a sticky link-up flag or a sticky link-down error flag.

Every interval is counted in periods of an external timebase tick. At the defaults, one tick is 1 µs: the hold is 250 ticks, the settle is 100 000 ticks, the poll period is 1000 ticks and the poll limit is 1000 samples. A bench can pass smaller values and a slower tick to shorten the run. The status word passes through a two-flop synchroniser before it is sampled.

The controller is a state machine with seven states:
- IDLE: after reset.
- HOLD: reset asserted.
- SETTLE: reset released, waiting before the first look at the link.
- SAMPLE: one cycle that reads the synchronised status.
- WAIT: the poll interval between samples.
- UP: terminal, link found.
- FAIL: terminal, samples exhausted.

The transitions are:
- start: from IDLE, UP or FAIL to HOLD.
- hold_done: HOLD to SETTLE.
- settle_done: SETTLE to SAMPLE.
- seen: SAMPLE to UP.
- retry: SAMPLE to WAIT.
- exhausted: SAMPLE to FAIL.
- poll_due: WAIT to SAMPLE.

Top module: `perst_link_ctrl`

## Requirements
- R1: Out of reset, rst_ctrl_o is 3'b000, and link_up_o and link_err_o are both 0.
- R2: A start strobe taken in IDLE, UP or FAIL clears all three rst_ctrl_o bits on the next clock edge. The same edge clears link_up_o and link_err_o. The rst_ctrl_o bits are: bit 2 endpoint reset source select, bit 1 endpoint-mode reset, bit 0 root reset-out.
- R3: rst_ctrl_o stays 3'b000 for exactly HOLD_TICKS ticks after the start is taken. It then becomes 3'b001, and bits 2 and 1 stay cleared until the next start. rst_ctrl_o takes no value other than 3'b000 or 3'b001.
- R4: The first status sample follows the release of reset by exactly SETTLE_TICKS ticks.
- R5: The link qualifies only when bit DLA_BIT (2) of the synchronised status word is 1. Bit 3, PHY link-up, has no effect on its own.
- R6: After the first sample, samples repeat every POLL_TICKS ticks, up to POLL_MAX samples in total. The first sample that sees the qualifying bit sets link_up_o, and this includes the final permitted sample.
- R7: If none of the POLL_MAX samples qualifies, link_err_o is set. This happens SETTLE_TICKS + (POLL_MAX-1)*POLL_TICKS ticks after reset is released.
- R8: link_up_o and link_err_o hold their value until the next start is taken, whatever the status word does. They are never set together.
- R9: A start strobe that arrives during HOLD, SETTLE, SAMPLE or WAIT is ignored, and the timing of the sequence in progress is unchanged.
- R10: The status word reaches the sampler through two flops. A status change made in the clock cycle that ends a poll interval is not seen until the next sample.
- R11: Intervals advance only on cycles where tick_i is 1. With tick_i held low the block stays in its current phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for a new reset and link-up sequence |
| tick_i | input | 1 | Timebase clock enable, one pulse per time unit |
| link_stat_i | input | STAT_W | Link-status word, asynchronous to clk |
| rst_ctrl_o | output | 3 | Reset controls: [2] source select, [1] endpoint-mode reset, [0] root reset-out |
| link_up_o | output | 1 | Sticky link-up flag |
| link_err_o | output | 1 | Sticky link-down error flag |

## Verification
The properties treat start_i, tick_i and the status word as free inputs. The one exception is the synchroniser-latency property, which assumes that the status word is sampled by clk at least twice after each change, as any value held for a cycle is. The interval checks in the stimulus depend on ticks being at least two clocks apart, so that no tick falls in the single SAMPLE cycle. To keep within that, the stimulus generates one tick every fourth clock and can gate ticks off entirely. Status changes are driven at the falling edge and are timed by counting observed ticks. This timing can place a change either well inside a poll interval or in the very cycle that closes one.

// File: rtl/perst_link_pkg.sv
package perst_link_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HOLD   = 3'd1,
        ST_SETTLE = 3'd2,
        ST_SAMPLE = 3'd3,
        ST_WAIT   = 3'd4,
        ST_UP     = 3'd5,
        ST_FAIL   = 3'd6
    } seq_state_t;

    localparam int CTRL_W = 3;

    // reset-control drive values
    localparam logic [CTRL_W-1:0] CTRL_ASSERTED = 3'b000;
    localparam logic [CTRL_W-1:0] CTRL_RELEASED = 3'b001;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/perst_tick_timer.sv
module perst_tick_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic          done_o
);
    logic [TW-1:0] remain_q;
    logic          active_q;

    // expires on the load_val-th tick after the load
    assign done_o = active_q && tick_i && (remain_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            active_q <= 1'b0;
        end else if (load_i) begin
            remain_q <= load_val_i - 1'b1;
            active_q <= 1'b1;
        end else if (done_o) begin
            active_q <= 1'b0;
        end else if (active_q && tick_i) begin
            remain_q <= remain_q - 1'b1;
        end
    end

endmodule

// File: rtl/perst_status_sync.sv
module perst_status_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q[b]   <= 1'b0;
                    stable_q[b] <= 1'b0;
                end else begin
                    meta_q[b]   <= async_i[b];
                    stable_q[b] <= meta_q[b];
                end
            end
        end
    endgenerate

    assign sync_o = stable_q;

endmodule

// File: rtl/perst_seq_fsm.sv
module perst_seq_fsm
    import perst_link_pkg::*;
#(
    parameter int HOLD_TICKS   = 250,
    parameter int SETTLE_TICKS = 100000,
    parameter int POLL_TICKS   = 1000,
    parameter int POLL_MAX     = 1000,
    parameter int TW           = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dla_i,
    input  logic              tmr_done_i,
    output logic              tmr_load_o,
    output logic [TW-1:0]     tmr_val_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              up_o,
    output logic              err_o
);
    localparam int SW = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
    localparam logic [SW-1:0] LAST_SAMPLE = SW'(POLL_MAX - 1);

    seq_state_t    state_q, state_n;
    logic [SW-1:0] samp_q;
    logic          samp_clr, samp_inc;

    // next-state and timer control
    always_comb begin
        state_n    = state_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = TW'(HOLD_TICKS);
        samp_clr   = 1'b0;
        samp_inc   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_UP, ST_FAIL: begin
                if (start_i) begin
                    state_n    = ST_HOLD;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = TW'(HOLD_TICKS);
                end
            end
            ST_HOLD: begin
                if (tmr_done_i) begin
                    state_n    = ST_SETTLE;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = TW'(SETTLE_TICKS);
                    samp_clr   = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tmr_done_i) state_n = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                if (dla_i) begin
                    state_n = ST_UP;
                end else if (samp_q == LAST_SAMPLE) begin
                    state_n = ST_FAIL;
                end else begin
                    state_n    = ST_WAIT;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = TW'(POLL_TICKS);
                    samp_inc   = 1'b1;
                end
            end
            ST_WAIT: begin
                if (tmr_done_i) state_n = ST_SAMPLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            samp_q  <= '0;
        end else begin
            state_q <= state_n;
            if (samp_clr)      samp_q <= '0;
            else if (samp_inc) samp_q <= samp_q + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_o <= CTRL_ASSERTED;
            up_o   <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            unique case (state_n)
                ST_HOLD:                                  ctrl_o <= CTRL_ASSERTED;
                ST_SETTLE, ST_SAMPLE, ST_WAIT, ST_UP, ST_FAIL: ctrl_o <= CTRL_RELEASED;
                default:                                  ctrl_o <= ctrl_o;
            endcase
            up_o  <= (state_n == ST_UP);
            err_o <= (state_n == ST_FAIL);
        end
    end

endmodule

// File: rtl/perst_link_ctrl.sv
module perst_link_ctrl
    import perst_link_pkg::*;
#(
    parameter int STAT_W       = 32,
    parameter int DLA_BIT      = 2,
    parameter int HOLD_TICKS   = 250,
    parameter int SETTLE_TICKS = 100000,
    parameter int POLL_TICKS   = 1000,
    parameter int POLL_MAX     = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              tick_i,
    input  logic [STAT_W-1:0] link_stat_i,
    output logic [2:0]        rst_ctrl_o,
    output logic              link_up_o,
    output logic              link_err_o
);
    localparam int MAX_IVL = max3(HOLD_TICKS, SETTLE_TICKS, POLL_TICKS);
    localparam int TW      = $clog2(MAX_IVL + 1);

    logic [STAT_W-1:0] stat_sync;
    logic              tmr_load, tmr_done;
    logic [TW-1:0]     tmr_val;

    perst_status_sync #(.W(STAT_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (link_stat_i),
        .sync_o  (stat_sync)
    );

    perst_tick_timer #(.TW(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    perst_seq_fsm #(
        .HOLD_TICKS   (HOLD_TICKS),
        .SETTLE_TICKS (SETTLE_TICKS),
        .POLL_TICKS   (POLL_TICKS),
        .POLL_MAX     (POLL_MAX),
        .TW           (TW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .dla_i      (stat_sync[DLA_BIT]),
        .tmr_done_i (tmr_done),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .ctrl_o     (rst_ctrl_o),
        .up_o       (link_up_o),
        .err_o      (link_err_o)
    );

endmodule

// File: rtl/perst_link_ctrl_chk.sv
module perst_link_ctrl_chk #(
    parameter int STAT_W  = 32,
    parameter int DLA_BIT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              tick_i,
    input logic [STAT_W-1:0] link_stat_i,
    input logic [2:0]        rst_ctrl_o,
    input logic              link_up_o,
    input logic              link_err_o
);
    // R3
    ctrl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_ctrl_o == 3'b000) || (rst_ctrl_o == 3'b001));

    // R8
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_up_o && link_err_o));

    // R8
    up_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up_o && !start_i) |=> link_up_o);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_err_o && !start_i) |=> link_err_o);

    // R2
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (link_up_o || link_err_o)) |=>
            (rst_ctrl_o == 3'b000) && !link_up_o && !link_err_o);

    // R2
    assert_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_ctrl_o[0]) |-> $past(start_i));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && rst_ctrl_o[0] && !link_up_o && !link_err_o) |=> rst_ctrl_o[0]);

    // R10
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up_o) |-> $past(link_stat_i[DLA_BIT], 2));

    // R7
    err_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_err_o) |-> (rst_ctrl_o == 3'b001));

endmodule

bind perst_link_ctrl perst_link_ctrl_chk #(.STAT_W(STAT_W), .DLA_BIT(DLA_BIT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .tick_i      (tick_i),
    .link_stat_i (link_stat_i),
    .rst_ctrl_o  (rst_ctrl_o),
    .link_up_o   (link_up_o),
    .link_err_o  (link_err_o)
);

// File: tb/perst_link_ctrl_bench.sv
`timescale 1ns/1ps
module perst_link_ctrl_bench;
    localparam int HOLD   = 5;
    localparam int SETTLE = 8;
    localparam int POLL   = 4;
    localparam int PMAX   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        tick = 1'b0;
    logic        tick_en = 1'b1;
    logic [31:0] stat = '0;
    logic [2:0]  ctrl;
    logic        up, err;
    int          div = 0;
    int          total = 0;
    int          fails = 0;

    always #10 clk = ~clk;

    // one tick every fourth clock, changed just after the rising edge
    always begin
        @(posedge clk);
        #2;
        div  = (div + 1) % 4;
        tick = tick_en && (div == 0);
    end

    perst_link_ctrl #(
        .STAT_W(32), .DLA_BIT(2), .HOLD_TICKS(HOLD), .SETTLE_TICKS(SETTLE),
        .POLL_TICKS(POLL), .POLL_MAX(PMAX)
    ) u_perst_link_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start), .tick_i(tick),
        .link_stat_i(stat), .rst_ctrl_o(ctrl), .link_up_o(up), .link_err_o(err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    // pulse start while idle or done; check the cleared state (R2)
    task automatic launch(input logic [31:0] init_stat);
        stat = init_stat;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(ctrl == 3'b000, "R2 ctrl cleared after start", ctrl, 0);
        chk(!up && !err, "R2 flags cleared after start", {up, err}, 0);
    endtask

    // counts ticks in the asserted and released phases until a flag is set
    task automatic measure(input int raise_at, input logic [31:0] raise_val,
                           input int inj_hold, input int inj_set,
                           output int hold_t, output int set_t);
        int  n = 0;
        bit  fin = 0;
        bit  bad = 0;
        hold_t = 0;
        set_t  = 0;
        while (!fin && n < 4000) begin
            if (up || err) fin = 1;
            else if (ctrl == 3'b000) begin
                if (tick) begin
                    hold_t++;
                    if (hold_t == inj_hold) start = 1'b1;
                end
            end else if (ctrl == 3'b001) begin
                if (tick) begin
                    set_t++;
                    if (set_t == raise_at) stat = raise_val;
                    if (set_t == inj_set) start = 1'b1;
                end
            end else begin
                bad = 1;
                fin = 1;
            end
            if (!fin) begin
                @(negedge clk);
                start = 1'b0;
                n++;
            end
        end
        chk(!bad, "R3 ctrl only 000 or 001", ctrl, 1);
        chk(n < 4000, "R6 sequence completes", n, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(ctrl == 3'b000, "R1 reset ctrl", ctrl, 0);
        chk(!up, "R1 reset link_up", up, 0);
        chk(!err, "R1 reset link_err", err, 0);
    endtask

    task automatic t_immediate();
        int h, s;
        launch(32'h4);
        measure(-1, 32'h4, -1, -1, h, s);
        chk(h == HOLD, "R3 hold ticks", h, HOLD);
        chk(s == SETTLE, "R4 settle ticks before first sample", s, SETTLE);
        chk(up && !err, "R6 link up on first sample", up, 1);
        chk(ctrl == 3'b001, "R3 only reset-out set after release", ctrl, 1);
    endtask

    task automatic t_mid_poll();
        int h, s;
        launch(32'h0);
        measure(SETTLE + 1, 32'h4, -1, -1, h, s);
        chk(s == SETTLE + POLL, "R6 link seen on second sample", s, SETTLE + POLL);
        chk(up && !err, "R6 link up flag", up, 1);
    endtask

    task automatic t_sync_edge();
        int h, s;
        launch(32'h0);
        measure(SETTLE + POLL, 32'h4, -1, -1, h, s);
        chk(s == SETTLE + 2 * POLL, "R10 late change waits for next sample", s, SETTLE + 2 * POLL);
        chk(up, "R10 link up after sync delay", up, 1);
    endtask

    task automatic t_phy_only();
        int h, s;
        launch(32'h8);
        measure(-1, 32'h8, -1, -1, h, s);
        chk(err && !up, "R5 bit 3 alone does not qualify", err, 1);
        chk(s == SETTLE + (PMAX - 1) * POLL, "R7 error time", s, SETTLE + (PMAX - 1) * POLL);
        stat = 32'h4;
        repeat (40) @(negedge clk);
        chk(err && !up, "R8 error sticky despite status", err, 1);
        chk(ctrl == 3'b001, "R8 ctrl stays released when failed", ctrl, 1);
    endtask

    task automatic t_last_sample();
        int h, s;
        launch(32'h0);
        measure(SETTLE + (PMAX - 2) * POLL + 1, 32'h4, -1, -1, h, s);
        chk(up && !err, "R6 link up on final sample", up, 1);
        chk(s == SETTLE + (PMAX - 1) * POLL, "R6 final sample time", s, SETTLE + (PMAX - 1) * POLL);
    endtask

    task automatic t_busy_start();
        int h, s;
        launch(32'h4);
        measure(-1, 32'h4, 2, 3, h, s);
        chk(h == HOLD, "R9 start during hold ignored", h, HOLD);
        chk(s == SETTLE, "R9 start during settle ignored", s, SETTLE);
        launch(32'h0);
        measure(SETTLE + 1, 32'h4, -1, SETTLE + 2, h, s);
        chk(s == SETTLE + POLL, "R9 start during poll wait ignored", s, SETTLE + POLL);
        stat = 32'h0;
        repeat (40) @(negedge clk);
        chk(up && !err, "R8 link up sticky after status drops", up, 1);
    endtask

    task automatic t_tick_stall();
        int h, s;
        tick_en = 1'b0;
        launch(32'h4);
        repeat (60) @(negedge clk);
        chk(ctrl == 3'b000, "R11 no progress without ticks", ctrl, 0);
        tick_en = 1'b1;
        measure(-1, 32'h4, -1, -1, h, s);
        chk(h == HOLD, "R11 hold counted in ticks only", h, HOLD);
        chk(up, "R11 sequence completes after ticks resume", up, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_immediate();
        t_mid_poll();
        t_sync_edge();
        t_phy_only();
        t_last_sample();
        t_busy_start();
        t_tick_stall();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

endmodule